// File: doc/BRIEF.md
# Control and Status Register Bank

This block is a slave register bank on an AXI4-Lite style bus. It holds four 32-bit registers and presents their contents to the surrounding logic as parallel ports. Software reaches them through the usual five channels: write address, write data, write response, read address and read data. Hardware reaches them through dedicated inputs and outputs. The four registers are a byte-maskable control word, a read-only view of a hardware status word, a bank of sticky event flags that software clears by writing ones, and a bank of request bits. A request bit is raised by software and held until hardware acknowledges it.

Elaboration parameters set the reset style (synchronous or asynchronous, applied to every flop), the number of flag and request bits, whether per-register write strobe outputs are driven, and what a read of a hole in the map does. Such a read can either return a fixed marker word with a good response or return an error response.

Top module: `csr_bank`

## Requirements
- R1: After reset all register outputs are zero and neither response channel is valid. With SYNC_RST=0 an active-low reset clears the registers at once, without a clock edge. With SYNC_RST=1 they clear only at the next rising clock edge.
- R2: The control register at byte offset 0x00 is read/write. Each byte lane k (bits 8k+7..8k) is written only when write strobe bit k is 1. ctrl_o and a read of 0x00 both show the stored word.
- R3: The flag register at offset 0x08 holds NFLAG sticky bits in its low bits. A one-cycle pulse on flag_set_i[i] sets bit i. A write clears bit i only when data bit i is 1 and its byte lane is enabled. A write of 0 changes nothing. When a set and a clear meet in the same cycle, the set wins.
- R4: The request register at offset 0x0C holds NREQ bits. A write of 1 with its lane enabled sets bit i. The bit then stays high on req_o until req_ack_i[i] is high on a clock edge, which clears it. When a write of 1 and an ack meet in the same cycle, the bit stays set.
- R5: Offset 0x04 reads stat_i as sampled at the read-address handshake. Writes to it change nothing and get response 00 (OKAY).
- R6: A read of any word index of 4 or more returns rresp 00 with rdata 0xDEADBEEF when MISS_MARK=1. When MISS_MARK=0 it returns rresp 10 (SLVERR) with rdata 0.
- R7: A write to any word index of 4 or more gets bresp 10 (SLVERR) and changes no register.
- R8: With HAS_STB=1, wr_stb_o[i] is high for exactly one cycle on each write to word index i (0 to 3), whatever the data. With HAS_STB=0, wr_stb_o stays 0.
- R9: The write address and write data may arrive in either order or together. The register update happens in the cycle after the later of the two handshakes, and bvalid rises at that same edge.
- R10: Only one write and one read are in flight at a time. While bvalid is high, awready and wready are low. bvalid and bresp hold until bready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| ctrl_o | output | 32 | Control register contents |
| stat_i | input | 32 | Hardware status word |
| flag_set_i | input | NFLAG | Sticky flag set events |
| flag_o | output | NFLAG | Sticky flag contents |
| req_o | output | NREQ | Pending request bits |
| req_ack_i | input | NREQ | Request acknowledges |
| wr_stb_o | output | 4 | Per-register write strobes |

## Verification
Two instances share one bus. One uses asynchronous reset, the marker word on read misses and strobes enabled. The other uses synchronous reset, error responses on read misses and strobes disabled. Mid-run reset separates the two reset styles, and reads and writes to map holes separate the two miss behaviours. Control writes use partial byte masks and all three channel orderings, which shows lane gating and the order independence of the write path. Flag and request writes land in the same cycle as a hardware set or acknowledge, which shows which side takes priority. Writes of zero and writes with a disabled lane show that those bits are left alone.

// File: rtl/csr_pkg.sv
package csr_pkg;
   localparam int REG_CNT = 4;
   typedef logic [1:0] reg_idx_t;
   localparam reg_idx_t IDX_CTRL = 2'd0;
   localparam reg_idx_t IDX_STAT = 2'd1;
   localparam reg_idx_t IDX_FLAG = 2'd2;
   localparam reg_idx_t IDX_REQ  = 2'd3;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   function automatic logic [31:0] lane_mask(input logic [3:0] s);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
      return m;
   endfunction
endpackage

// File: rtl/csr_dff.sv
module csr_dff #(
   parameter int W = 1,
   parameter bit SYNC_RST = 1'b0,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (SYNC_RST) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= INIT;
            else if (en) q <= d;
         end
      end else begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= INIT;
            else if (en) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/csr_wr_chan.sv
module csr_wr_chan #(
   parameter int IDX_W = 6,
   parameter bit SYNC_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             awvalid,
   output logic             awready,
   input  logic [IDX_W-1:0] awidx,
   input  logic             wvalid,
   output logic             wready,
   input  logic [31:0]      wdata,
   input  logic [3:0]       wstrb,
   output logic             bvalid,
   input  logic             bready,
   output logic [1:0]       bresp,
   input  logic             wr_hit_i,
   output logic             wr_go,
   output logic [IDX_W-1:0] wr_idx,
   output logic [31:0]      wr_data,
   output logic [3:0]       wr_strb
);
   import csr_pkg::*;

   logic aw_held, w_held, b_pend;
   logic aw_hs, w_hs;
   logic aw_held_d, w_held_d, b_pend_d;
   logic [1:0] resp_d;

   assign awready = !aw_held && !b_pend;
   assign wready  = !w_held && !b_pend;
   assign aw_hs   = awvalid && awready;
   assign w_hs    = wvalid && wready;
   assign wr_go   = aw_held && w_held && !b_pend;
   assign bvalid  = b_pend;

   assign aw_held_d = wr_go ? 1'b0 : (aw_held || aw_hs);
   assign w_held_d  = wr_go ? 1'b0 : (w_held || w_hs);
   assign b_pend_d  = wr_go || (b_pend && !bready);
   assign resp_d    = wr_hit_i ? RESP_OKAY : RESP_SLVERR;

   csr_dff #(.W(1), .SYNC_RST(SYNC_RST)) u_awh (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(aw_held_d), .q(aw_held));
   csr_dff #(.W(1), .SYNC_RST(SYNC_RST)) u_wh (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(w_held_d), .q(w_held));
   csr_dff #(.W(1), .SYNC_RST(SYNC_RST)) u_bp (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(b_pend_d), .q(b_pend));
   csr_dff #(.W(2), .SYNC_RST(SYNC_RST)) u_br (
      .clk(clk), .rst_n(rst_n), .en(wr_go), .d(resp_d), .q(bresp));
   csr_dff #(.W(IDX_W), .SYNC_RST(SYNC_RST)) u_ad (
      .clk(clk), .rst_n(rst_n), .en(aw_hs), .d(awidx), .q(wr_idx));
   csr_dff #(.W(32), .SYNC_RST(SYNC_RST)) u_wd (
      .clk(clk), .rst_n(rst_n), .en(w_hs), .d(wdata), .q(wr_data));
   csr_dff #(.W(4), .SYNC_RST(SYNC_RST)) u_ws (
      .clk(clk), .rst_n(rst_n), .en(w_hs), .d(wstrb), .q(wr_strb));
endmodule

// File: rtl/csr_rd_chan.sv
module csr_rd_chan #(
   parameter bit SYNC_RST = 1'b0,
   parameter bit MISS_MARK = 1'b1,
   parameter logic [31:0] MARK_WORD = 32'hDEAD_BEEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        arvalid,
   output logic        arready,
   output logic        rvalid,
   input  logic        rready,
   output logic [31:0] rdata,
   output logic [1:0]  rresp,
   input  logic        rd_hit_i,
   input  logic [31:0] rd_word_i
);
   import csr_pkg::*;

   logic r_pend, ar_hs, r_pend_d;
   logic [31:0] data_d;
   logic [1:0]  resp_d;

   assign arready  = !r_pend;
   assign ar_hs    = arvalid && arready;
   assign rvalid   = r_pend;
   assign r_pend_d = ar_hs || (r_pend && !rready);

   generate
      if (MISS_MARK) begin : g_mark
         assign data_d = rd_hit_i ? rd_word_i : MARK_WORD;
         assign resp_d = RESP_OKAY;
      end else begin : g_err
         assign data_d = rd_hit_i ? rd_word_i : 32'h0;
         assign resp_d = rd_hit_i ? RESP_OKAY : RESP_SLVERR;
      end
   endgenerate

   csr_dff #(.W(1), .SYNC_RST(SYNC_RST)) u_rp (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(r_pend_d), .q(r_pend));
   csr_dff #(.W(32), .SYNC_RST(SYNC_RST)) u_rd (
      .clk(clk), .rst_n(rst_n), .en(ar_hs), .d(data_d), .q(rdata));
   csr_dff #(.W(2), .SYNC_RST(SYNC_RST)) u_rr (
      .clk(clk), .rst_n(rst_n), .en(ar_hs), .d(resp_d), .q(rresp));
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
   parameter int NFLAG = 8,
   parameter int NREQ = 4,
   parameter bit SYNC_RST = 1'b0,
   parameter bit HAS_STB = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  csr_pkg::reg_idx_t   wr_idx,
   input  logic [31:0]         wr_data,
   input  logic [3:0]          wr_strb,
   input  csr_pkg::reg_idx_t   rd_idx,
   output logic [31:0]         rd_word,
   input  logic [31:0]         stat_i,
   input  logic [NFLAG-1:0]    flag_set_i,
   input  logic [NREQ-1:0]     req_ack_i,
   output logic [31:0]         ctrl_o,
   output logic [NFLAG-1:0]    flag_o,
   output logic [NREQ-1:0]     req_o,
   output logic [3:0]          wr_stb_o
);
   import csr_pkg::*;

   logic [31:0]      wmask, wbits;
   logic [NFLAG-1:0] flag_clr, flag_d;
   logic [NREQ-1:0]  req_set, req_d;

   assign wmask = lane_mask(wr_strb);
   assign wbits = wr_data & wmask;

   genvar b;
   generate
      for (b = 0; b < 4; b++) begin : g_ctrl
         csr_dff #(.W(8), .SYNC_RST(SYNC_RST)) u_byte (
            .clk(clk), .rst_n(rst_n),
            .en(wr_en && wr_idx == IDX_CTRL && wr_strb[b]),
            .d(wr_data[b*8 +: 8]), .q(ctrl_o[b*8 +: 8]));
      end
   endgenerate

   assign flag_clr = (wr_en && wr_idx == IDX_FLAG) ? wbits[NFLAG-1:0] : '0;
   assign flag_d   = (flag_o & ~flag_clr) | flag_set_i;
   csr_dff #(.W(NFLAG), .SYNC_RST(SYNC_RST)) u_flag (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(flag_d), .q(flag_o));

   assign req_set = (wr_en && wr_idx == IDX_REQ) ? wbits[NREQ-1:0] : '0;
   assign req_d   = (req_o & ~req_ack_i) | req_set;
   csr_dff #(.W(NREQ), .SYNC_RST(SYNC_RST)) u_req (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(req_d), .q(req_o));

   genvar i;
   generate
      if (HAS_STB) begin : g_stb
         for (i = 0; i < REG_CNT; i++) begin : g_bit
            assign wr_stb_o[i] = wr_en && (wr_idx == reg_idx_t'(i));
         end
      end else begin : g_nostb
         assign wr_stb_o = '0;
      end
   endgenerate

   always_comb begin
      case (rd_idx)
         IDX_CTRL: rd_word = ctrl_o;
         IDX_STAT: rd_word = stat_i;
         IDX_FLAG: rd_word = 32'(flag_o);
         default:  rd_word = 32'(req_o);
      endcase
   end
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
   parameter int ADDR_W = 8,
   parameter int NFLAG = 8,
   parameter int NREQ = 4,
   parameter bit SYNC_RST = 1'b0,
   parameter bit MISS_MARK = 1'b1,
   parameter bit HAS_STB = 1'b1,
   parameter logic [31:0] MARK_WORD = 32'hDEAD_BEEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [31:0]       s_wdata,
   input  logic [3:0]        s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic [31:0]       ctrl_o,
   input  logic [31:0]       stat_i,
   input  logic [NFLAG-1:0]  flag_set_i,
   output logic [NFLAG-1:0]  flag_o,
   output logic [NREQ-1:0]   req_o,
   input  logic [NREQ-1:0]   req_ack_i,
   output logic [3:0]        wr_stb_o
);
   import csr_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   generate
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_aw
         $error("csr_bank: ADDR_W must lie in 5..32");
      end
      if (NFLAG < 1 || NFLAG > 32) begin : g_bad_nf
         $error("csr_bank: NFLAG must lie in 1..32");
      end
      if (NREQ < 1 || NREQ > 32) begin : g_bad_nr
         $error("csr_bank: NREQ must lie in 1..32");
      end
   endgenerate

   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [31:0]      wr_data, rd_word;
   logic [3:0]       wr_strb;
   logic             wr_go, wr_hit, rd_hit;
   logic             unused_lsb;

   assign unused_lsb = ^{s_awaddr[1:0], s_araddr[1:0]};
   assign rd_idx = s_araddr[ADDR_W-1:2];
   assign wr_hit = wr_idx < IDX_W'(REG_CNT);
   assign rd_hit = rd_idx < IDX_W'(REG_CNT);

   csr_wr_chan #(.IDX_W(IDX_W), .SYNC_RST(SYNC_RST)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .awvalid(s_awvalid), .awready(s_awready), .awidx(s_awaddr[ADDR_W-1:2]),
      .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
      .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
      .wr_hit_i(wr_hit), .wr_go(wr_go), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_strb(wr_strb));

   csr_rd_chan #(.SYNC_RST(SYNC_RST), .MISS_MARK(MISS_MARK), .MARK_WORD(MARK_WORD)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .arvalid(s_arvalid), .arready(s_arready),
      .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
      .rd_hit_i(rd_hit), .rd_word_i(rd_word));

   csr_regfile #(.NFLAG(NFLAG), .NREQ(NREQ), .SYNC_RST(SYNC_RST), .HAS_STB(HAS_STB)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_go && wr_hit), .wr_idx(wr_idx[1:0]),
      .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_idx(rd_idx[1:0]), .rd_word(rd_word),
      .stat_i(stat_i), .flag_set_i(flag_set_i), .req_ack_i(req_ack_i),
      .ctrl_o(ctrl_o), .flag_o(flag_o), .req_o(req_o), .wr_stb_o(wr_stb_o));
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
   parameter int NFLAG = 8,
   parameter int NREQ = 4,
   parameter bit MISS_MARK = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s_awready,
   input logic             s_wready,
   input logic             s_bvalid,
   input logic             s_bready,
   input logic [1:0]       s_bresp,
   input logic             s_rvalid,
   input logic [1:0]       s_rresp,
   input logic [NFLAG-1:0] flag_set_i,
   input logic [NFLAG-1:0] flag_o,
   input logic [NREQ-1:0]  req_o,
   input logic [NREQ-1:0]  req_ack_i,
   input logic [3:0]       wr_stb_o
);
   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_i[0] |=> flag_o[0]);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o[0] && !req_ack_i[0]) |=> req_o[0]);

   // R10
   b_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

   // R10
   aw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> (!s_awready && !s_wready));

   // R6
   miss_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && MISS_MARK) |-> (s_rresp == 2'b00));

   // R8
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o));
endmodule

bind csr_bank csr_bank_chk #(.NFLAG(NFLAG), .NREQ(NREQ), .MISS_MARK(MISS_MARK)) u_chk (.*);

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
   logic [7:0]  awaddr = 0, araddr = 0;
   logic [31:0] wdata = 0, stat = 0;
   logic [3:0]  wstrb = 0;
   logic [7:0]  fset = 0;
   logic [3:0]  rack = 0;

   logic        d_awready, d_wready, d_bvalid, d_arready, d_rvalid;
   logic [1:0]  d_bresp, d_rresp;
   logic [31:0] d_rdata, d_ctrl;
   logic [7:0]  d_flag;
   logic [3:0]  d_req, d_stb;
   logic        a_awready, a_wready, a_bvalid, a_arready, a_rvalid;
   logic [1:0]  a_bresp, a_rresp;
   logic [31:0] a_rdata, a_ctrl;
   logic [7:0]  a_flag;
   logic [3:0]  a_req, a_stb;

   csr_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(awvalid), .s_awready(d_awready), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(d_wready), .s_wdata(wdata), .s_wstrb(wstrb),
      .s_bvalid(d_bvalid), .s_bready(bready), .s_bresp(d_bresp),
      .s_arvalid(arvalid), .s_arready(d_arready), .s_araddr(araddr),
      .s_rvalid(d_rvalid), .s_rready(rready), .s_rdata(d_rdata), .s_rresp(d_rresp),
      .ctrl_o(d_ctrl), .stat_i(stat), .flag_set_i(fset), .flag_o(d_flag),
      .req_o(d_req), .req_ack_i(rack), .wr_stb_o(d_stb));

   csr_bank #(.SYNC_RST(1'b1), .MISS_MARK(1'b0), .HAS_STB(1'b0)) u_alt (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(awvalid), .s_awready(a_awready), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(a_wready), .s_wdata(wdata), .s_wstrb(wstrb),
      .s_bvalid(a_bvalid), .s_bready(bready), .s_bresp(a_bresp),
      .s_arvalid(arvalid), .s_arready(a_arready), .s_araddr(araddr),
      .s_rvalid(a_rvalid), .s_rready(rready), .s_rdata(a_rdata), .s_rresp(a_rresp),
      .ctrl_o(a_ctrl), .stat_i(stat), .flag_set_i(fset), .flag_o(a_flag),
      .req_o(a_req), .req_ack_i(rack), .wr_stb_o(a_stb));

   int total = 0, bad = 0;
   bit done = 0;
   int stb_cnt [4] = '{0, 0, 0, 0};
   bit alt_stb_seen = 0;
   logic [1:0]  wr_resp;
   logic [31:0] rd_d, rd_a;
   logic [1:0]  rs_d, rs_a;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) stb_cnt[i] += int'(d_stb[i]);
         if (a_stb != 0) alt_stb_seen = 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // order: 0 together, 1 data first, 2 address first
   task automatic wr(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] strb,
                     input int order, input logic [7:0] cset, input logic [3:0] cack,
                     input bit stall);
      @(negedge clk);
      awaddr = addr; wdata = data; wstrb = strb; bready = !stall;
      if (order != 1) awvalid = 1;
      if (order != 2) wvalid = 1;
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      if (order == 1) begin awvalid = 1; @(negedge clk); awvalid = 0; end
      else if (order == 2) begin wvalid = 1; @(negedge clk); wvalid = 0; end
      else begin fset = cset; rack = cack; end
      @(negedge clk);
      fset = 0; rack = 0;
      while (!d_bvalid) @(negedge clk);
      wr_resp = d_bresp;
      chk("R9 alt bresp", {30'd0, a_bresp}, {30'd0, d_bresp});
      if (stall) begin
         chk("R10 ready low", {30'd0, d_awready, d_wready}, 32'd0);
         @(negedge clk);
         chk("R10 bvalid held", {31'd0, d_bvalid}, 32'd1);
         bready = 1;
      end
      @(negedge clk);
      bready = 0;
   endtask

   task automatic rd(input logic [7:0] addr);
      @(negedge clk);
      araddr = addr; arvalid = 1;
      @(negedge clk);
      arvalid = 0; rready = 1;
      rd_d = d_rdata; rs_d = d_rresp; rd_a = a_rdata; rs_a = a_rresp;
      chk("R10 rvalid", {31'd0, d_rvalid}, 32'd1);
      @(negedge clk);
      rready = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctrl", d_ctrl, 0);
      chk("R1 alt ctrl", a_ctrl, 0);
      chk("R1 flag", {24'd0, d_flag}, 0);
      chk("R1 req", {28'd0, d_req}, 0);
      chk("R1 valids", {30'd0, d_bvalid, d_rvalid}, 0);

      // R2 byte lanes
      wr(8'h00, 32'h1122_3344, 4'b0101, 0, 0, 0, 0);
      chk("R2 bresp", {30'd0, wr_resp}, 0);
      chk("R2 ctrl", d_ctrl, 32'h0022_0044);
      wr(8'h00, 32'hAABB_CCDD, 4'b1010, 0, 0, 0, 0);
      chk("R2 ctrl merge", d_ctrl, 32'hAA22_CC44);
      rd(8'h00);
      chk("R2 readback", rd_d, 32'hAA22_CC44);

      // R9 channel order
      wr(8'h00, 32'h0102_0304, 4'hF, 1, 0, 0, 0);
      chk("R9 data first", d_ctrl, 32'h0102_0304);
      wr(8'h00, 32'h0A0B_0C0D, 4'hF, 2, 0, 0, 0);
      chk("R9 addr first", d_ctrl, 32'h0A0B_0C0D);

      // R5 status
      stat = 32'h1357_2468;
      rd(8'h04);
      chk("R5 read", rd_d, 32'h1357_2468);
      wr(8'h04, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0);
      chk("R5 bresp", {30'd0, wr_resp}, 0);
      rd(8'h04);
      chk("R5 unchanged", rd_d, 32'h1357_2468);
      stat = 32'h0;
      rd(8'h04);
      chk("R5 live", rd_d, 32'h0);

      // R3 sticky flags
      @(negedge clk); fset = 8'hA5;
      @(negedge clk); fset = 0;
      repeat (2) @(negedge clk);
      chk("R3 set", {24'd0, d_flag}, 32'hA5);
      wr(8'h08, 32'h81, 4'h1, 0, 0, 0, 0);
      chk("R3 clear", {24'd0, d_flag}, 32'h24);
      wr(8'h08, 32'hFF, 4'hE, 0, 0, 0, 0);
      chk("R3 lane off", {24'd0, d_flag}, 32'h24);
      wr(8'h08, 32'h00, 4'hF, 0, 0, 0, 0);
      chk("R3 zero", {24'd0, d_flag}, 32'h24);
      wr(8'h08, 32'h24, 4'hF, 0, 8'h04, 0, 0);
      chk("R3 set wins", {24'd0, d_flag}, 32'h04);
      rd(8'h08);
      chk("R3 read", rd_d, 32'h04);

      // R4 request / acknowledge
      wr(8'h0C, 32'h5, 4'hF, 0, 0, 0, 0);
      chk("R4 set", {28'd0, d_req}, 32'h5);
      repeat (3) @(negedge clk);
      chk("R4 held", {28'd0, d_req}, 32'h5);
      rack = 4'h1;
      @(negedge clk); rack = 0;
      chk("R4 ack", {28'd0, d_req}, 32'h4);
      wr(8'h0C, 32'h4, 4'hF, 0, 0, 4'h4, 0);
      chk("R4 write wins", {28'd0, d_req}, 32'h4);
      rack = 4'h4;
      @(negedge clk); rack = 0;
      rd(8'h0C);
      chk("R4 read", rd_d, 32'h0);

      // R6 read miss
      rd(8'h10);
      chk("R6 mark data", rd_d, 32'hDEAD_BEEF);
      chk("R6 mark resp", {30'd0, rs_d}, 0);
      chk("R6 err data", rd_a, 0);
      chk("R6 err resp", {30'd0, rs_a}, 32'h2);
      rd(8'hFC);
      chk("R6 top mark", rd_d, 32'hDEAD_BEEF);
      chk("R6 top err", {30'd0, rs_a}, 32'h2);

      // R7 write miss
      wr(8'h20, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0);
      chk("R7 bresp", {30'd0, wr_resp}, 32'h2);
      chk("R7 ctrl kept", d_ctrl, 32'h0A0B_0C0D);
      chk("R7 flag kept", {24'd0, d_flag}, 32'h04);

      // R10 stalled response
      wr(8'h00, 32'h5555_AAAA, 4'hF, 0, 0, 0, 1);
      chk("R10 ctrl", d_ctrl, 32'h5555_AAAA);

      // R8 strobe counts
      chk("R8 ctrl stb", stb_cnt[0], 5);
      chk("R8 stat stb", stb_cnt[1], 1);
      chk("R8 flag stb", stb_cnt[2], 4);
      chk("R8 req stb", stb_cnt[3], 2);
      chk("R8 alt none", {31'd0, alt_stb_seen}, 0);

      // R1 reset styles
      @(negedge clk);
      rst_n = 0;
      #1;
      chk("R1 async clear", d_ctrl, 0);
      chk("R1 sync wait", a_ctrl, 32'h5555_AAAA);
      @(negedge clk);
      chk("R1 sync clear", a_ctrl, 0);
      rst_n = 1;

      done = 1;
      finish_run();
   end
endmodule